// File: doc/BRIEF.md
# Bit-Serial LMS Coefficient Updater

This block keeps the coefficient set of a 16-tap adaptive FIR filter and refreshes it once per sample period with the least-mean-square rule. Each refresh adds a scaled copy of the product of the error and the reference sample to every stored coefficient. The scale is a step size of 2^-s. An upstream stage supplies the error and the reference vector. The filter reads the coefficient bus.

All numbers are Q15 two's complement. There is no parallel multiplier. Each error-times-reference product is built one multiplier bit per clock in a shift-and-add accumulator. Two such accumulators run side by side, so a full refresh of all 16 taps takes 136 clocks. That fits inside a 200-clock sample period. The logic grows with the number of lanes, not with the number of taps.

An update starts when the error strobe is sampled high while the block is idle. The block captures the error, the step exponent and all reference samples at that edge. It walks through the taps in pairs and marks completion with a one-clock strobe. A strobe that arrives before completion is ignored and is reported with an overrun pulse.

Top module: `lms_coef_updater`

## Requirements
- R1: While reset is low, and in the first cycle after it, every coefficient on `coefOut` reads 0, and `updateDone` and `overrun` are low.
- R2: An accepted update changes tap n, found on `coefOut[16n+15:16n]`, to sat(h + floor(e·u_n / 2^(15+s))). Here h is the old coefficient. e is `errIn` and u_n is `refIn[16n+15:16n]`, both signed 16-bit. s is `muShift`. e, u_n and s are the values captured at the accepting edge.
- R3: The updated coefficient saturates to the range -32768 to 32767 instead of wrapping.
- R4: Every step exponent s from 0 to 15 applies a right shift with floor rounding. s is taken from the accepting edge only.
- R5: Taps are written in pairs (2r, 2r+1) for round r = 0..7. The write happens on the clock edge 17·(r+1) cycles after the accepting edge. Every coefficient not being written holds its value.
- R6: `updateDone` is high for exactly one cycle. It follows the edge 136 cycles after the accepting edge, the same edge that writes taps 14 and 15.
- R7: A strobe sampled while an update is in progress, including on its final write edge, makes `overrun` high for the next cycle. It does not alter the running update. Changes on `errIn`, `refIn` and `muShift` after the accepting edge do not alter it either.
- R8: A strobe sampled on the edge 137 cycles after the accepting edge, or later, starts a new update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| errValid | input | 1 | Error strobe; starts an update when the block is idle |
| errIn | input | 16 | Error sample e, signed Q15 |
| muShift | input | 4 | Step exponent s; the step size is 2^-s |
| refIn | input | 256 | Reference samples; tap n at bits 16n+15:16n, signed Q15 |
| coefOut | output | 256 | Coefficients; tap n at bits 16n+15:16n, signed Q15 |
| updateDone | output | 1 | One-cycle pulse when all taps are written |
| overrun | output | 1 | One-cycle pulse after a strobe that arrived while busy |

## Verification
Counting from the edge that accepts a strobe, each result has a fixed due edge. Coefficient pair r changes on edge 17·(r+1). The done pulse follows edge 136. An overrun pulse follows the edge on which the rejected strobe was sampled.

The bench holds a behavioural model that counts the same edges from its own captured copy of the inputs. It compares every coefficient, the done strobe and the overrun flag on each falling edge. That is half a cycle after any registered change, so an output that moves one edge early or late is caught in the cycle where it differs. Rejected strobes are placed both mid-update and exactly on the final write edge. A new strobe follows one edge later to probe the acceptance boundary.

// File: rtl/lms_pkg.sv
package lms_pkg;

  // strobes from the sequencer to the arithmetic
  typedef struct packed {
    logic load;      // capture inputs, clear accumulators
    logic clear;     // clear accumulators, reload multiplier bits
    logic stepEn;    // one shift-and-add step
    logic lastStep;  // sign-bit step: subtract, no shift
    logic write;     // commit lane results to coefficients
  } lmsStrobes_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_MUL   = 2'd1,
    ST_WRITE = 2'd2
  } lmsState_e;

endpackage

// File: rtl/lms_serial_mac.sv
module lms_serial_mac #(
  parameter int DW   = 16,
  parameter int ACCW = 19
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   clear,
  input  logic                   stepEn,
  input  logic                   lastStep,
  input  logic                   bitIn,
  input  logic signed [DW-1:0]   mcand,
  output logic signed [ACCW-1:0] acc
);

  logic signed [ACCW-1:0] addend;
  logic signed [ACCW-1:0] sumV;

  // LSB-first multiplier bits; the partial product is kept right-aligned,
  // so the low product bits fall off with floor rounding
  always_comb begin
    addend = bitIn ? {{(ACCW-DW){mcand[DW-1]}}, mcand} : '0;
    sumV   = lastStep ? (acc - addend) : (acc + addend);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      acc <= '0;
    end else if (clear) begin
      acc <= '0;
    end else if (stepEn) begin
      acc <= lastStep ? sumV : (sumV >>> 1);
    end
  end

endmodule

// File: rtl/lms_datapath.sv
module lms_datapath
  import lms_pkg::*;
#(
  parameter int NTAPS  = 16,
  parameter int DW     = 16,
  parameter int ACCW   = 19,
  parameter int NLANES = 2,
  parameter int SHW    = 4
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  lmsStrobes_t                 strb,
  input  logic [$clog2(NTAPS)-$clog2(NLANES)-1:0] roundIdx,
  input  logic [DW-1:0]               errIn,
  input  logic [SHW-1:0]              muShift,
  input  logic [NTAPS*DW-1:0]         refIn,
  output logic [NTAPS*DW-1:0]         coefOut
);

  localparam int TW = $clog2(NTAPS);
  localparam int LW = $clog2(NLANES);
  localparam int RW = TW - LW;
  localparam logic signed [ACCW:0] MAXV = (ACCW+1)'((2**(DW-1)) - 1);
  localparam logic signed [ACCW:0] MINV = ~MAXV;

  logic [DW-1:0]         errHold;
  logic [DW-1:0]         errShift;
  logic [SHW-1:0]        muReg;
  logic signed [DW-1:0]  refReg  [NTAPS];
  logic signed [DW-1:0]  coefReg [NTAPS];

  logic [TW-1:0]          laneTap    [NLANES];
  logic signed [ACCW-1:0] laneAcc    [NLANES];
  logic signed [ACCW-1:0] laneScaled [NLANES];
  logic signed [ACCW:0]   laneSum    [NLANES];
  logic signed [DW-1:0]   laneNew    [NLANES];

  // captured operands; the error is replayed bit by bit every round
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      errHold  <= '0;
      errShift <= '0;
      muReg    <= '0;
      for (int n = 0; n < NTAPS; n++) refReg[n] <= '0;
    end else if (strb.load) begin
      errHold  <= errIn;
      errShift <= errIn;
      muReg    <= muShift;
      for (int n = 0; n < NTAPS; n++) refReg[n] <= refIn[n*DW +: DW];
    end else if (strb.clear) begin
      errShift <= errHold;
    end else if (strb.stepEn) begin
      errShift <= errShift >> 1;
    end
  end

  for (genvar l = 0; l < NLANES; l++) begin : g_lane
    // interleaved: round r, lane l serves tap r*NLANES+l
    assign laneTap[l] = {roundIdx[RW-1:0], LW'(l)};

    lms_serial_mac #(.DW(DW), .ACCW(ACCW)) u_mac (
      .clk      (clk),
      .rstN     (rstN),
      .clear    (strb.load | strb.clear),
      .stepEn   (strb.stepEn),
      .lastStep (strb.lastStep),
      .bitIn    (errShift[0]),
      .mcand    (refReg[laneTap[l]]),
      .acc      (laneAcc[l])
    );

    assign laneScaled[l] = laneAcc[l] >>> muReg;
    assign laneSum[l] = {{(ACCW+1-DW){coefReg[laneTap[l]][DW-1]}}, coefReg[laneTap[l]]}
                      + {laneScaled[l][ACCW-1], laneScaled[l]};
    assign laneNew[l] = (laneSum[l] > MAXV) ? MAXV[DW-1:0] :
                        (laneSum[l] < MINV) ? MINV[DW-1:0] : laneSum[l][DW-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int n = 0; n < NTAPS; n++) coefReg[n] <= '0;
    end else if (strb.write) begin
      for (int l = 0; l < NLANES; l++) coefReg[laneTap[l]] <= laneNew[l];
    end
  end

  for (genvar n = 0; n < NTAPS; n++) begin : g_out
    assign coefOut[n*DW +: DW] = coefReg[n];
  end

  // R5: coefficients move only on a write strobe
  p_coef_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    !strb.write |=> $stable(coefOut));

endmodule

// File: rtl/lms_control.sv
module lms_control
  import lms_pkg::*;
#(
  parameter int NTAPS  = 16,
  parameter int DW     = 16,
  parameter int NLANES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        errValid,
  output lmsStrobes_t strb,
  output logic [$clog2(NTAPS)-$clog2(NLANES)-1:0] roundIdx,
  output logic        updateDone,
  output logic        overrun
);

  localparam int ROUNDS = NTAPS / NLANES;
  localparam int RW     = $clog2(NTAPS) - $clog2(NLANES);
  localparam int CW     = $clog2(DW);

  lmsState_e     state;
  logic [CW-1:0] stepCnt;
  logic [RW-1:0] roundCnt;
  logic          lastRound;

  assign lastRound = (roundCnt == RW'(ROUNDS - 1));
  assign roundIdx  = roundCnt;

  always_comb begin
    strb = '0;
    case (state)
      ST_IDLE:  strb.load = errValid;
      ST_MUL: begin
        strb.stepEn   = 1'b1;
        strb.lastStep = (stepCnt == CW'(DW - 1));
      end
      ST_WRITE: begin
        strb.write = 1'b1;
        strb.clear = 1'b1;
      end
      default: strb = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      stepCnt    <= '0;
      roundCnt   <= '0;
      updateDone <= 1'b0;
      overrun    <= 1'b0;
    end else begin
      updateDone <= 1'b0;
      overrun    <= errValid && (state != ST_IDLE);
      case (state)
        ST_IDLE: begin
          if (errValid) begin
            state    <= ST_MUL;
            stepCnt  <= '0;
            roundCnt <= '0;
          end
        end
        ST_MUL: begin
          stepCnt <= stepCnt + 1'b1;
          if (stepCnt == CW'(DW - 1)) state <= ST_WRITE;
        end
        ST_WRITE: begin
          stepCnt <= '0;
          if (lastRound) begin
            state      <= ST_IDLE;
            updateDone <= 1'b1;
          end else begin
            roundCnt <= roundCnt + 1'b1;
            state    <= ST_MUL;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R6: completion strobe lasts one cycle and leaves the block idle
  p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rstN)
    updateDone |=> !updateDone);
  p_done_idle_r6: assert property (@(posedge clk) disable iff (!rstN)
    updateDone |-> (state == ST_IDLE));
  // R7: overrun only follows a strobe taken while busy
  p_overrun_src_r7: assert property (@(posedge clk) disable iff (!rstN)
    overrun |-> ($past(errValid) && ($past(state) != ST_IDLE)));
  // R8: an idle strobe always starts the multiply phase
  p_start_r8: assert property (@(posedge clk) disable iff (!rstN)
    (errValid && state == ST_IDLE) |=> (state == ST_MUL));

endmodule

// File: rtl/lms_coef_updater.sv
module lms_coef_updater
  import lms_pkg::*;
#(
  parameter int NTAPS  = 16,
  parameter int DW     = 16,
  parameter int ACCW   = 19,
  parameter int NLANES = 2,
  parameter int SHW    = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                errValid,
  input  logic [DW-1:0]       errIn,
  input  logic [SHW-1:0]      muShift,
  input  logic [NTAPS*DW-1:0] refIn,
  output logic [NTAPS*DW-1:0] coefOut,
  output logic                updateDone,
  output logic                overrun
);

  localparam int RW = $clog2(NTAPS) - $clog2(NLANES);

  lmsStrobes_t   strb;
  logic [RW-1:0] roundIdx;

  lms_control #(.NTAPS(NTAPS), .DW(DW), .NLANES(NLANES)) u_ctl (
    .clk        (clk),
    .rstN       (rstN),
    .errValid   (errValid),
    .strb       (strb),
    .roundIdx   (roundIdx),
    .updateDone (updateDone),
    .overrun    (overrun)
  );

  lms_datapath #(.NTAPS(NTAPS), .DW(DW), .ACCW(ACCW), .NLANES(NLANES), .SHW(SHW)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .roundIdx (roundIdx),
    .errIn    (errIn),
    .muShift  (muShift),
    .refIn    (refIn),
    .coefOut  (coefOut)
  );

endmodule

// File: tb/lms_coef_updater_test.sv
module lms_coef_updater_test;

  localparam int NT = 16;
  localparam int DW = 16;
  localparam int SW = 4;
  localparam int RLEN = 17;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic              rstN = 1'b0;
  logic              errValid = 1'b0;
  logic [DW-1:0]     errIn = '0;
  logic [SW-1:0]     muShift = '0;
  logic [NT*DW-1:0]  refIn = '0;
  logic [NT*DW-1:0]  coefOut;
  logic              updateDone;
  logic              overrun;

  lms_coef_updater uut (
    .clk(clk), .rstN(rstN), .errValid(errValid), .errIn(errIn),
    .muShift(muShift), .refIn(refIn), .coefOut(coefOut),
    .updateDone(updateDone), .overrun(overrun)
  );

  int    checks = 0;
  int    errors = 0;
  string curReq = "R1";

  // behavioural model state
  int mCoef [NT];
  int mRef  [NT];
  int mErr, mShift, mCnt, mRound;
  bit mBusy, mDone, mOver;

  function automatic int updTap(int h, int e, int u, int s);
    longint p = longint'(e) * longint'(u);
    longint d = p >>> (15 + s);
    longint t = longint'(h) + d;
    if (t > 32767) t = 32767;
    if (t < -32768) t = -32768;
    return int'(t);
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      for (int n = 0; n < NT; n++) begin mCoef[n] = 0; mRef[n] = 0; end
      mBusy = 0; mDone = 0; mOver = 0; mCnt = 0;
    end else begin
      mDone = 0;
      mOver = 0;
      if (mBusy) begin
        if (errValid) mOver = 1;
        mCnt++;
        if (mCnt % RLEN == 0) begin
          mRound = mCnt / RLEN - 1;
          for (int l = 0; l < 2; l++)
            mCoef[2*mRound+l] = updTap(mCoef[2*mRound+l], mErr, mRef[2*mRound+l], mShift);
          if (mRound == NT/2 - 1) begin mBusy = 0; mDone = 1; end
        end
      end else if (errValid) begin
        mErr   = int'($signed(errIn));
        mShift = int'(muShift);
        for (int n = 0; n < NT; n++) mRef[n] = int'($signed(refIn[n*DW +: DW]));
        mBusy = 1;
        mCnt  = 0;
      end
    end
  end

  // compare every cycle, half a period after the registered changes
  always @(negedge clk) begin
    if (rstN) begin
      for (int n = 0; n < NT; n++) begin
        checks++;
        if (int'($signed(coefOut[n*DW +: DW])) != mCoef[n]) begin
          errors++;
          $display("FAIL %s coef[%0d] actual %0d expected %0d at %0t", curReq, n,
                   int'($signed(coefOut[n*DW +: DW])), mCoef[n], $time);
        end
      end
      checks++;
      if (updateDone !== mDone) begin
        errors++;
        $display("FAIL R6 updateDone actual %0b expected %0b at %0t", updateDone, mDone, $time);
      end
      checks++;
      if (overrun !== mOver) begin
        errors++;
        $display("FAIL R7 overrun actual %0b expected %0b at %0t", overrun, mOver, $time);
      end
    end
  end

  function automatic logic [15:0] refVal(int n, int seed);
    int v;
    if (seed == 0) return 16'h7fff;
    if (seed == 2 && n == 5) return 16'h8000;
    v = n * 7919 + seed * 104729 + n * n * 331;
    return v[15:0];
  endfunction

  task automatic strobe(int e, int s, int seed);
    errIn   = e[15:0];
    muShift = s[3:0];
    for (int n = 0; n < NT; n++) refIn[n*DW +: DW] = refVal(n, seed);
    errValid = 1'b1;
    @(negedge clk);
    errValid = 1'b0;
  endtask

  task automatic waitN(int k);
    repeat (k) @(negedge clk);
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    checks++;
    if (coefOut !== '0 || updateDone !== 1'b0 || overrun !== 1'b0) begin
      errors++;
      $display("FAIL R1 reset outputs actual %h/%b/%b expected 0/0/0", coefOut, updateDone, overrun);
    end
    rstN = 1'b1;
    @(negedge clk);
    curReq = "R1";
    waitN(2);

    // R2 and R5: basic rule, pairwise write timing
    curReq = "R2";
    strobe(16384, 0, 1);
    waitN(140);
    curReq = "R5";
    strobe(-7777, 1, 7);
    waitN(140);

    // R4: several step exponents, including u = -32768
    curReq = "R4";
    strobe(-12345, 3, 2);
    waitN(140);
    strobe(20000, 15, 3);
    waitN(140);
    strobe(-32768, 7, 4);
    waitN(140);

    // R3: drive coefficients into both rails
    curReq = "R3";
    for (int i = 0; i < 3; i++) begin strobe(32767, 0, 0); waitN(140); end
    for (int i = 0; i < 4; i++) begin strobe(-32768, 0, 0); waitN(140); end

    // R7: strobe mid-update, then scramble inputs while busy
    curReq = "R7";
    strobe(1000, 2, 5);
    waitN(40);
    strobe(-30000, 0, 6);
    for (int i = 0; i < 20; i++) begin
      errIn = 16'(i * 4099); muShift = 4'(i); refIn = {NT{16'(i * 977)}};
      @(negedge clk);
    end
    waitN(90);

    // R8: strobe on the final write edge is rejected, the next one accepted
    curReq = "R8";
    strobe(5000, 1, 8);
    waitN(135);
    strobe(-4000, 0, 9);
    strobe(12000, 2, 10);
    waitN(140);

    summary();
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired at %0t", $time);
    summary();
    $finish;
  end

endmodule